// File: doc/BRIEF.md
# Inbound Address Window Translator

This block turns the 34-bit address carried by an inbound memory request into a 32-bit address on the local bus. It holds a set of programmable windows, sixteen by default. Each window has three registers: a base, a mask and a local offset. A 32-bit register port sets them up and reads them back. The register port is a plain combinational read mux with a single-cycle write strobe.

A request is presented with a strobe, a kind code and its address. The block compares the address with every enabled window at the same time. The lowest-numbered window that matches supplies the translated address. One clock after the strobe the block returns a valid pulse, a hit flag, the index of the winning window and the local address. Only the four memory request kinds (read, write, write with acknowledge, streaming write) are translated. Any other kind still gets its one-cycle response, but the hit flag is always low.

A window matches when the address and the window base agree on every bit where the 34-bit mask is one. The local address takes the window offset and fills in the address bits where the mask is zero.

Top module: `inb_addr_xlat`

## Requirements
- R1: Window n (0 to NUM_WIN-1) decodes its base register at byte address 0x10300 + 0x10*n, its mask register at +0x4 and its offset register at +0x8. A write updates only the addressed register. Only word-aligned addresses (address bits [1:0] = 0) are decoded.
- R2: Base register layout. Bits [31:3] hold base address bits 31..3 and bits [1:0] hold base bits 33..32. Bit 2 always reads 0 and writes to it are dropped. Base bits 2..0 are treated as zero.
- R3: Mask register layout. Bits [31:3] hold mask bits 31..3 and bits [1:0] hold mask bits 33..32. Mask bits 2..0 are treated as zero. Bit 2 is a read/write window enable.
- R4: Offset register layout. Bits [31:3] hold local address bits 31..3. Bits [2:0] always read 0 and writes to them are dropped.
- R5: Synchronous active-high reset clears every register field to zero. After reset, every register reads 0 and no request hits.
- R6: A window matches when (address AND mask) equals (base AND mask) over all 34 bits, including bits 33..32.
- R7: On a hit, the local address is offset OR (address[31:0] AND NOT mask[31:0]).
- R8: When several windows match, the lowest-numbered one wins, and its index is reported on rsp_win.
- R9: A window whose enable bit is 0 never matches, whatever its base and mask.
- R10: Kind codes 0 (read), 1 (write), 2 (write with acknowledge) and 3 (streaming write) are translated. For codes 4 to 7, rsp_hit stays 0.
- R11: rsp_valid is high in exactly the cycle after each cycle with req_valid high. rsp_hit is never high without rsp_valid.
- R12: Reads of the fourth word of a window slot (+0xC), of unaligned addresses, and of addresses outside 0x10300..0x103FF return 0. Writes to those addresses change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 17 | Register byte address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr (combinational) |
| req_valid | input | 1 | Translation request strobe |
| req_kind | input | 3 | Request kind code (0 to 3 are translated) |
| req_addr | input | 34 | Inbound packet-space address |
| rsp_valid | output | 1 | Result valid, one cycle after req_valid |
| rsp_hit | output | 1 | A window matched |
| rsp_win | output | 4 | Index of the winning window |
| rsp_addr | output | 32 | Translated local address (meaningful when rsp_hit) |

## Verification
The assertions check several properties on every cycle:
- the one-cycle response timing;
- that an untranslated kind never raises the hit flag;
- that the priority grant is at most one-hot and appears whenever any window matches;
- that reserved read-back bits stay zero;
- that reset leaves every window disabled.

The bench's scenarios are the only place where the following are shown:
- the exact 34-bit compare, including a mismatch confined to the top two address bits;
- the translated address values;
- lowest-index selection among overlapping windows;
- the effect of the enable bit;
- that writes to unmapped words leave the window registers untouched.

The bench checks these against its behavioural model on every clock.

// File: rtl/axlat_pkg.sv
package axlat_pkg;

    localparam int PADDR_W   = 34;
    localparam int LADDR_W   = 32;
    localparam int REG_W     = 32;
    localparam int CFG_AW    = 17;
    localparam int MAX_WIN   = 16;
    localparam int WIN_IDX_W = 4;

    // Upper address bits that select the window register block
    localparam logic [CFG_AW-9:0] BLOCK_PAGE = 9'h103;

    localparam logic [2:0] KIND_READ     = 3'd0;
    localparam logic [2:0] KIND_WRITE    = 3'd1;
    localparam logic [2:0] KIND_WRITE_AK = 3'd2;
    localparam logic [2:0] KIND_STREAM_W = 3'd3;

    typedef enum logic [1:0] {
        SEL_BASE = 2'd0,
        SEL_MASK = 2'd1,
        SEL_OFFS = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [PADDR_W-1:0] base;
        logic [PADDR_W-1:0] mask;
        logic [LADDR_W-1:0] offset;
        logic               en;
    } win_cfg_t;

    typedef struct packed {
        logic                 valid;
        logic                 hit;
        logic [WIN_IDX_W-1:0] win;
        logic [LADDR_W-1:0]   laddr;
    } xlat_rsp_t;

    function automatic logic is_xlat_kind(input logic [2:0] k);
        return (k == KIND_READ) || (k == KIND_WRITE) ||
               (k == KIND_WRITE_AK) || (k == KIND_STREAM_W);
    endfunction

endpackage

// File: rtl/axlat_regs.sv
module axlat_regs
    import axlat_pkg::*;
#(
    parameter int NUM_WIN = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_wr,
    input  logic [CFG_AW-1:0]   cfg_addr,
    input  logic [REG_W-1:0]    cfg_wdata,
    output logic [REG_W-1:0]    cfg_rdata,
    output win_cfg_t            win_cfg [NUM_WIN]
);

    localparam logic [WIN_IDX_W:0] NWIN_L = (WIN_IDX_W+1)'(NUM_WIN);

    logic                 in_block;
    logic                 win_ok;
    logic [WIN_IDX_W-1:0] widx;
    reg_sel_e             sel;
    logic                 wr_ok;
    logic [NUM_WIN-1:0]   en_vec;

    logic [REG_W-1:0] rd_base [NUM_WIN];
    logic [REG_W-1:0] rd_mask [NUM_WIN];
    logic [REG_W-1:0] rd_offs [NUM_WIN];

    assign in_block = (cfg_addr[CFG_AW-1:8] == BLOCK_PAGE) && (cfg_addr[1:0] == 2'b00);
    assign widx     = cfg_addr[7:4];
    assign sel      = reg_sel_e'(cfg_addr[3:2]);
    assign win_ok   = in_block && ({1'b0, widx} < NWIN_L);
    assign wr_ok    = cfg_wr && win_ok;

    generate
        for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
            logic [28:0] base_hi, mask_hi, offs_hi;
            logic [1:0]  base_x, mask_x;
            logic        en_r;

            always_ff @(posedge clk) begin
                if (rst) begin
                    base_hi <= '0;
                    base_x  <= '0;
                    mask_hi <= '0;
                    mask_x  <= '0;
                    en_r    <= 1'b0;
                    offs_hi <= '0;
                end else if (wr_ok && (widx == WIN_IDX_W'(w))) begin
                    case (sel)
                        SEL_BASE: begin
                            base_hi <= cfg_wdata[31:3];
                            base_x  <= cfg_wdata[1:0];
                        end
                        SEL_MASK: begin
                            mask_hi <= cfg_wdata[31:3];
                            en_r    <= cfg_wdata[2];
                            mask_x  <= cfg_wdata[1:0];
                        end
                        SEL_OFFS: offs_hi <= cfg_wdata[31:3];
                        default: ;
                    endcase
                end
            end

            assign rd_base[w] = {base_hi, 1'b0, base_x};
            assign rd_mask[w] = {mask_hi, en_r, mask_x};
            assign rd_offs[w] = {offs_hi, 3'b000};
            assign en_vec[w]  = en_r;

            assign win_cfg[w].base   = {base_x, base_hi, 3'b000};
            assign win_cfg[w].mask   = {mask_x, mask_hi, 3'b000};
            assign win_cfg[w].offset = {offs_hi, 3'b000};
            assign win_cfg[w].en     = en_r;
        end
    endgenerate

    always_comb begin
        cfg_rdata = '0;
        for (int w = 0; w < NUM_WIN; w++) begin
            if (win_ok && (widx == WIN_IDX_W'(w))) begin
                case (sel)
                    SEL_BASE: cfg_rdata = rd_base[w];
                    SEL_MASK: cfg_rdata = rd_mask[w];
                    SEL_OFFS: cfg_rdata = rd_offs[w];
                    default:  cfg_rdata = '0;
                endcase
            end
        end
    end

    AST_RST_ALL_DISABLED: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (en_vec == '0)); // R5
    AST_BASE_RSV_ZERO: assert property (@(posedge clk) disable iff (rst)
        (in_block && sel == SEL_BASE) |-> (cfg_rdata[2] == 1'b0)); // R2
    AST_OFFS_RSV_ZERO: assert property (@(posedge clk) disable iff (rst)
        (in_block && sel == SEL_OFFS) |-> (cfg_rdata[2:0] == 3'b000)); // R4
    AST_SPARE_SLOT_ZERO: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_NONE || !in_block) |-> (cfg_rdata == '0)); // R12

endmodule

// File: rtl/axlat_match.sv
module axlat_match
    import axlat_pkg::*;
#(
    parameter int NUM_WIN = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  win_cfg_t              win_cfg [NUM_WIN],
    input  logic [PADDR_W-1:0]    addr,
    output logic                  hit,
    output logic [WIN_IDX_W-1:0]  win_idx,
    output logic [LADDR_W-1:0]    laddr
);

    logic [NUM_WIN-1:0] hit_vec;
    logic [NUM_WIN-1:0] grant;
    logic [LADDR_W-1:0] xl [NUM_WIN];

    generate
        for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
            assign hit_vec[w] = win_cfg[w].en &&
                (((addr ^ win_cfg[w].base) & win_cfg[w].mask) == '0);
            assign xl[w] = win_cfg[w].offset |
                (addr[LADDR_W-1:0] & ~win_cfg[w].mask[LADDR_W-1:0]);
        end
    endgenerate

    // Fixed priority: lowest index wins
    always_comb begin
        logic seen;
        seen  = 1'b0;
        grant = '0;
        for (int w = 0; w < NUM_WIN; w++) begin
            if (hit_vec[w] && !seen) begin
                grant[w] = 1'b1;
                seen     = 1'b1;
            end
        end
    end

    always_comb begin
        win_idx = '0;
        laddr   = '0;
        for (int w = 0; w < NUM_WIN; w++) begin
            if (grant[w]) begin
                win_idx = WIN_IDX_W'(w);
                laddr   = laddr | xl[w];
            end
        end
    end

    assign hit = |grant;

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant)); // R8
    AST_GRANT_WITHIN_HITS: assert property (@(posedge clk) disable iff (rst)
        (grant & ~hit_vec) == '0); // R8
    AST_ANY_MATCH_GRANTS: assert property (@(posedge clk) disable iff (rst)
        (hit_vec != '0) |-> hit); // R6

endmodule

// File: rtl/inb_addr_xlat.sv
module inb_addr_xlat
    import axlat_pkg::*;
#(
    parameter int NUM_WIN = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cfg_wr,
    input  logic [16:0]  cfg_addr,
    input  logic [31:0]  cfg_wdata,
    output logic [31:0]  cfg_rdata,
    input  logic         req_valid,
    input  logic [2:0]   req_kind,
    input  logic [33:0]  req_addr,
    output logic         rsp_valid,
    output logic         rsp_hit,
    output logic [3:0]   rsp_win,
    output logic [31:0]  rsp_addr
);

    localparam logic [WIN_IDX_W:0] NWIN_L = (WIN_IDX_W+1)'(NUM_WIN);

    win_cfg_t             win_cfg [NUM_WIN];
    logic                 m_hit;
    logic [WIN_IDX_W-1:0] m_win;
    logic [LADDR_W-1:0]   m_laddr;
    xlat_rsp_t            rsp_q;

    axlat_regs #(.NUM_WIN(NUM_WIN)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_wr    (cfg_wr),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .win_cfg   (win_cfg)
    );

    axlat_match #(.NUM_WIN(NUM_WIN)) u_match (
        .clk     (clk),
        .rst     (rst),
        .win_cfg (win_cfg),
        .addr    (req_addr),
        .hit     (m_hit),
        .win_idx (m_win),
        .laddr   (m_laddr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q <= '0;
        end else begin
            rsp_q.valid <= req_valid;
            rsp_q.hit   <= req_valid && is_xlat_kind(req_kind) && m_hit;
            rsp_q.win   <= m_hit ? m_win : '0;
            rsp_q.laddr <= m_laddr;
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_hit   = rsp_q.hit;
    assign rsp_win   = rsp_q.win;
    assign rsp_addr  = rsp_q.laddr;

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid); // R11
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid); // R11
    AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        rsp_hit |-> rsp_valid); // R11
    AST_OTHER_KIND_MISS: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kind[2]) |=> !rsp_hit); // R10
    AST_WIN_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        rsp_hit |-> ({1'b0, rsp_win} < NWIN_L)); // R8

endmodule

// File: tb/tb_inb_addr_xlat.sv
module tb_inb_addr_xlat;

    localparam int CLK_PERIOD = 10;
    localparam int NW         = 16;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_wr;
    logic [16:0] cfg_addr;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata;
    logic        req_valid;
    logic [2:0]  req_kind;
    logic [33:0] req_addr;
    logic        rsp_valid;
    logic        rsp_hit;
    logic [3:0]  rsp_win;
    logic [31:0] rsp_addr;

    inb_addr_xlat #(.NUM_WIN(NW)) dut (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
        .req_kind(req_kind), .req_addr(req_addr), .rsp_valid(rsp_valid),
        .rsp_hit(rsp_hit), .rsp_win(rsp_win), .rsp_addr(rsp_addr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural model: raw register words as software would read them
    logic [31:0] m_base [NW];
    logic [31:0] m_mask [NW];
    logic [31:0] m_off  [NW];

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    always @(posedge clk) cyc++;

    initial begin
        wait (cyc >= WATCHDOG);
        n_bad++;
        $display("FAIL R11 watchdog: actual %0d cycles expected below %0d", cyc, WATCHDOG);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] m_read(input logic [16:0] a);
        if (a[16:8] != 9'h103 || a[1:0] != 2'b00) return 32'h0;
        case (a[3:2])
            2'd0: return m_base[a[7:4]];
            2'd1: return m_mask[a[7:4]];
            2'd2: return m_off[a[7:4]];
            default: return 32'h0;
        endcase
    endfunction

    function automatic void m_write(input logic [16:0] a, input logic [31:0] d);
        if (a[16:8] != 9'h103 || a[1:0] != 2'b00) return;
        case (a[3:2])
            2'd0: m_base[a[7:4]] = d & 32'hFFFF_FFFB;
            2'd1: m_mask[a[7:4]] = d;
            2'd2: m_off[a[7:4]]  = d & 32'hFFFF_FFF8;
            default: ;
        endcase
    endfunction

    function automatic logic [33:0] wide(input logic [31:0] r);
        return {r[1:0], r[31:3], 3'b000};
    endfunction

    function automatic void m_xlat(input logic [2:0] k, input logic [33:0] a,
                                   output logic hit, output logic [3:0] win,
                                   output logic [31:0] la);
        hit = 1'b0; win = 4'd0; la = 32'h0;
        if (k > 3'd3) return;
        for (int i = 0; i < NW; i++) begin
            logic [33:0] b, m;
            b = wide(m_base[i]);
            m = wide(m_mask[i]);
            if (m_mask[i][2] && ((a & m) == (b & m))) begin
                hit = 1'b1;
                win = 4'(i);
                la  = m_off[i] | (a[31:0] & ~m[31:0]);
                return;
            end
        end
    endfunction

    function automatic logic [16:0] radr(input int w, input int s);
        return {9'h103, 4'(w), 2'(s), 2'b00};
    endfunction

    // One clock: drive at negedge, check read mux, check registered result next negedge
    task automatic step(input string tag, input logic wr, input logic [16:0] a,
                        input logic [31:0] wd, input logic rv, input logic [2:0] k,
                        input logic [33:0] ra);
        logic e_hit;
        logic [3:0] e_win;
        logic [31:0] e_la;
        cfg_wr = wr; cfg_addr = a; cfg_wdata = wd;
        req_valid = rv; req_kind = k; req_addr = ra;
        #1;
        chk({tag, " rdata"}, 64'(cfg_rdata), 64'(m_read(a)));
        m_xlat(k, ra, e_hit, e_win, e_la);
        e_hit = e_hit & rv;
        @(posedge clk);
        if (wr) m_write(a, wd);
        @(negedge clk);
        chk({tag, " R11 rsp_valid"}, 64'(rsp_valid), 64'(rv));
        chk({tag, " rsp_hit"}, 64'(rsp_hit), 64'(e_hit));
        if (e_hit) begin
            chk({tag, " R8 rsp_win"}, 64'(rsp_win), 64'(e_win));
            chk({tag, " R7 rsp_addr"}, 64'(rsp_addr), 64'(e_la));
        end
    endtask

    task automatic wr_reg(input string tag, input logic [16:0] a, input logic [31:0] d);
        step(tag, 1'b1, a, d, 1'b0, 3'd0, 34'h0);
    endtask

    task automatic rd_reg(input string tag, input logic [16:0] a);
        step(tag, 1'b0, a, 32'h0, 1'b0, 3'd0, 34'h0);
    endtask

    task automatic req(input string tag, input logic [2:0] k, input logic [33:0] ra);
        step(tag, 1'b0, 17'h0, 32'h0, 1'b1, k, ra);
    endtask

    initial begin
        for (int i = 0; i < NW; i++) begin
            m_base[i] = '0; m_mask[i] = '0; m_off[i] = '0;
        end
        rst = 1'b1; cfg_wr = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        req_valid = 1'b0; req_kind = '0; req_addr = '0;
        repeat (3) @(negedge clk);
        chk("R5 reset rsp_valid", 64'(rsp_valid), 64'd0);
        chk("R5 reset rsp_hit", 64'(rsp_hit), 64'd0);
        rst = 1'b0;

        // R5: every register reads zero, nothing hits
        for (int w = 0; w < NW; w++)
            for (int s = 0; s < 4; s++) rd_reg("R5", radr(w, s));
        req("R5 miss after reset", 3'd0, 34'h0_0000_0000);
        req("R5 miss after reset", 3'd1, 34'h3_FFFF_FFF8);

        // Window 0: base 0x2_4000_0000, mask 0x3_F000_0000, offset 0x8000_0000; junk in reserved bits
        wr_reg("R1 R2", radr(0, 0), {32'h4000_0000 | 32'h4 | 32'h2});
        wr_reg("R1 R3", radr(0, 1), {32'hF000_0000 | 32'h4 | 32'h3});
        wr_reg("R1 R4", radr(0, 2), 32'h8000_0007);
        rd_reg("R2 base readback", radr(0, 0));
        rd_reg("R3 mask readback", radr(0, 1));
        rd_reg("R4 offset readback", radr(0, 2));
        rd_reg("R1 neighbour untouched", radr(1, 0));

        req("R7 hit w0", 3'd0, 34'h2_4123_4567);
        req("R6 top bits differ", 3'd0, 34'h0_4123_4567);
        req("R6 bit32 differs", 3'd1, 34'h3_4123_4567);
        req("R6 high nibble differs", 3'd2, 34'h2_5123_4567);

        // Window 3 overlaps window 0
        wr_reg("R1", radr(3, 0), 32'h4100_0002);
        wr_reg("R1", radr(3, 1), 32'hFF00_0007);
        wr_reg("R1", radr(3, 2), 32'h1000_0000);
        req("R8 overlap lowest wins", 3'd3, 34'h2_4123_4567);
        // Disable window 0 so window 3 takes over
        wr_reg("R9 disable w0", radr(0, 1), 32'hF000_0003);
        req("R9 w0 off", 3'd0, 34'h2_4123_4567);
        req("R9 w0 off miss", 3'd0, 34'h2_4223_4567);

        // Window 5 covers everything but is disabled
        wr_reg("R9", radr(5, 2), 32'h0000_1000);
        req("R9 disabled catch-all", 3'd0, 34'h1_2345_6788);
        wr_reg("R3 enable w5", radr(5, 1), 32'h0000_0004);
        req("R3 catch-all live", 3'd0, 34'h1_2345_6788);
        req("R8 w3 beats w5", 3'd1, 34'h2_4123_4567);

        // R10: kind codes
        for (int k = 0; k < 8; k++) req("R10 kind", 3'(k), 34'h2_4155_0000);

        // R11: idle gaps and back-to-back
        step("R11 idle", 1'b0, 17'h0, 32'h0, 1'b0, 3'd0, 34'h2_4123_4567);
        req("R11 b2b", 3'd0, 34'h2_4100_0010);
        req("R11 b2b", 3'd2, 34'h0_0000_0040);
        step("R11 idle", 1'b0, 17'h0, 32'h0, 1'b0, 3'd0, 34'h0);

        // R12: spare slot, unaligned and out-of-block writes are dropped
        wr_reg("R12 spare slot", radr(2, 3), 32'hFFFF_FFFF);
        rd_reg("R12 spare slot", radr(2, 3));
        wr_reg("R12 outside block", 17'h10200, 32'hFFFF_FFFF);
        wr_reg("R12 outside block", 17'h10400, 32'hFFFF_FFFF);
        wr_reg("R12 unaligned", radr(2, 0) | 17'h1, 32'hFFFF_FFFF);
        rd_reg("R12 w2 base intact", radr(2, 0));
        rd_reg("R12 w0 base intact", radr(0, 0));
        rd_reg("R12 outside reads 0", 17'h10200);

        // Mixed random traffic against the model
        for (int n = 0; n < 600; n++) begin
            int w;
            logic [33:0] ra;
            w = int'($urandom_range(0, NW-1));
            if ($urandom_range(0, 3) == 0) begin
                logic [31:0] d;
                d = $urandom;
                if ($urandom_range(0, 1) == 0) d = d | 32'hFF00_0007;
                step("R1 R6 R7 random cfg", 1'b1, radr(w, int'($urandom_range(0, 3))), d,
                     1'($urandom_range(0, 1)), 3'($urandom_range(0, 4)),
                     {2'($urandom), 32'($urandom)});
            end else begin
                ra = wide(m_base[w]) ^ ({2'b00, 32'($urandom)} & {2'b00, 32'h00FF_FFFF});
                if ($urandom_range(0, 7) == 0) ra[33:32] = ~ra[33:32];
                step("R6 R7 R8 random req", 1'b0, radr(w, int'($urandom_range(0, 3))), 32'h0,
                     1'($urandom_range(0, 3) != 0), 3'($urandom_range(0, 4)), ra);
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule